// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Process Tags

This block caches page translations for a small set of pages. It turns a virtual page number into a physical frame number. Every entry carries a process tag next to its virtual page number. A lookup hits only when that tag equals the current-process register. Software can therefore load a new process identifier on a context switch without flushing anything. The translations of other processes stay resident and hit again once their identifier is loaded back.

A lookup is answered one cycle after the request with one of four result codes. A successful answer also carries the physical address. Refills arrive from outside on a one-cycle write port, and the block chooses the slot. Maintenance commands drop either every entry or only the entries of one process.

The low entries are set aside for operating-system translations, and user refills never land there. Inside each region a refill takes the lowest empty slot first. When the region is full, it evicts the lowest slot that was not the most recently hit entry.

Top module: `tlb_fa`

## Requirements
- R1: After reset `res_valid` is 0, the current-process register is 0, every entry is empty, and any lookup reports MISS.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `lk_req` high, and 0 otherwise.
- R3: A lookup matches an entry only if the entry is occupied, its page number equals `lk_vaddr[31:12]`, and its process tag equals the current-process register. On HIT (code 0), `res_paddr` is the frame number followed by `lk_vaddr[11:0]`.
- R4: A write to the process register leaves every entry untouched and takes effect for lookups from the next cycle on. Entries of an earlier process hit again once its identifier is restored.
- R5: The checks run in a fixed order. No match gives MISS (code 1). A match whose page-valid bit is clear gives FAULT (code 2), whatever the protection bits and the access kind.
- R6: Protection bits are bit 0 read, bit 1 write and bit 2 user. A valid match gives VIOLATION (code 3) in three cases: a store without the write bit, a load without the read bit, or a user-mode access (`lk_user`=1) without the user bit.
- R7: A HIT store sets the entry's dirty bit. On HIT, `res_dirty` shows the entry's dirty bit after the access. Loads, faults and violations leave the dirty bit unchanged. A refill clears it.
- R8: A refill with `fill_os`=1 targets entries 0..3, and one with `fill_os`=0 targets entries 4..15. It writes the lowest-indexed empty entry of that region. If the region has no empty entry, it writes the lowest-indexed entry that is not the most recently hit one (the most recent hit is entry 0 after reset).
- R9: A user refill (`fill_os`=0) never overwrites entries 0..3.
- R10: `inv_en` with `inv_all`=1 empties all entries. With `inv_all`=0 it empties only the entries whose process tag equals `inv_pid`.
- R11: A lookup in the same cycle as `fill_en` or `inv_en` reports MISS and changes no entry. When `fill_en` and `inv_en` are both high, the refill is done and the invalidate is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid_wr_en | input | 1 | Load the current-process register |
| pid_wr_data | input | 8 | New process identifier |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user-mode access |
| fill_en | input | 1 | Refill write |
| fill_os | input | 1 | Refill targets the reserved region |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_pid | input | 8 | Refill process tag |
| fill_pfn | input | 20 | Refill frame number |
| fill_pv | input | 1 | Refill page-valid bit |
| fill_prot | input | 3 | Refill protection bits (read, write, user) |
| inv_en | input | 1 | Invalidate command |
| inv_all | input | 1 | Invalidate every entry |
| inv_pid | input | 8 | Process tag to invalidate |
| res_valid | output | 1 | Result valid |
| res_code | output | 2 | 0 HIT, 1 MISS, 2 FAULT, 3 VIOLATION |
| res_paddr | output | 32 | Physical address on HIT, else 0 |
| res_dirty | output | 1 | Dirty bit after the access on HIT, else 0 |

## Verification
Every lookup result is due exactly one clock edge after its request. Refills, invalidates and process-register writes take effect at that same edge, so the next request already sees them. The bench keeps a behavioural model that applies each cycle's inputs at the rising edge, just as the design does. At every falling edge it compares the registered result with the model. Replacement effects are therefore checked one cycle after the refill, through the lookups that follow it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_FAULT = 2'd2,
        RES_VIOL  = 2'd3
    } res_code_e;

    localparam int PROT_BITS = 3;
    localparam int PROT_RD   = 0;
    localparam int PROT_WR   = 1;
    localparam int PROT_USR  = 2;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            occ_i,
    input  logic [N-1:0][VPN_W-1:0] vpn_i,
    input  logic [N-1:0][PID_W-1:0] pid_i,
    input  logic [VPN_W-1:0]        look_vpn_i,
    input  logic [PID_W-1:0]        cur_pid_i,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        idx_o
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = occ_i[g] && (vpn_i[g] == look_vpn_i) && (pid_i[g] == cur_pid_i);
    end

    always_comb begin
        hit_o = |eq;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N    = 16,
    parameter int OS_N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     occ_i,
    input  logic [IDX_W-1:0] mru_i,
    input  logic             os_sel_i,
    output logic [IDX_W-1:0] vic_o
);
    logic             got_free, got_old;
    logic [IDX_W-1:0] free_idx, old_idx;

    always_comb begin
        got_free = 1'b0;
        got_old  = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if ((os_sel_i && i < OS_N) || (!os_sel_i && i >= OS_N)) begin
                if (!occ_i[i] && !got_free) begin
                    got_free = 1'b1;
                    free_idx = IDX_W'(i);
                end
                if (IDX_W'(i) != mru_i && !got_old) begin
                    got_old = 1'b1;
                    old_idx = IDX_W'(i);
                end
            end
        end
        vic_o = got_free ? free_idx : old_idx;
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
    parameter int N     = 16,
    parameter int OS_N  = 4,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int PID_W = 8,
    parameter int OFF_W = 12,
    localparam int IDX_W = $clog2(N),
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pid_wr_en,
    input  logic [PID_W-1:0]               pid_wr_data,
    input  logic                           lk_req,
    input  logic [VA_W-1:0]                lk_vaddr,
    input  logic                           lk_store,
    input  logic                           lk_user,
    input  logic                           fill_en,
    input  logic                           fill_os,
    input  logic [VPN_W-1:0]               fill_vpn,
    input  logic [PID_W-1:0]               fill_pid,
    input  logic [PFN_W-1:0]               fill_pfn,
    input  logic                           fill_pv,
    input  logic [tlb_pkg::PROT_BITS-1:0]  fill_prot,
    input  logic                           inv_en,
    input  logic                           inv_all,
    input  logic [PID_W-1:0]               inv_pid,
    output logic                           res_valid,
    output logic [1:0]                     res_code,
    output logic [PA_W-1:0]                res_paddr,
    output logic                           res_dirty
);
    import tlb_pkg::*;

    typedef struct packed {
        logic                 occ;
        logic [VPN_W-1:0]     vpn;
        logic [PID_W-1:0]     pid;
        logic [PFN_W-1:0]     pfn;
        logic                 pv;
        logic [PROT_BITS-1:0] prot;
        logic                 dirty;
    } entry_t;

    typedef struct packed {
        entry_t [N-1:0]   ent;
        logic [PID_W-1:0] cur_pid;
        logic [IDX_W-1:0] mru;
        logic             rv;
        logic [1:0]       rc;
        logic [PA_W-1:0]  rpa;
        logic             rd;
    } state_t;

    state_t q, d;

    logic [N-1:0]            occ_v;
    logic [N-1:0][VPN_W-1:0] vpn_v;
    logic [N-1:0][PID_W-1:0] pid_v;
    logic                    hit_any;
    logic [IDX_W-1:0]        hit_idx, victim;
    entry_t                  sel;
    logic                    maint;

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign occ_v[g] = q.ent[g].occ;
        assign vpn_v[g] = q.ent[g].vpn;
        assign pid_v[g] = q.ent[g].pid;
    end

    tlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
        .occ_i      (occ_v),
        .vpn_i      (vpn_v),
        .pid_i      (pid_v),
        .look_vpn_i (lk_vaddr[VA_W-1:OFF_W]),
        .cur_pid_i  (q.cur_pid),
        .hit_o      (hit_any),
        .idx_o      (hit_idx)
    );

    tlb_victim #(.N(N), .OS_N(OS_N)) u_victim (
        .occ_i    (occ_v),
        .mru_i    (q.mru),
        .os_sel_i (fill_os),
        .vic_o    (victim)
    );

    assign sel   = q.ent[hit_idx];
    assign maint = fill_en || inv_en;

    always_comb begin
        d     = q;
        d.rv  = lk_req;
        d.rc  = RES_MISS;
        d.rpa = '0;
        d.rd  = 1'b0;
        if (pid_wr_en) d.cur_pid = pid_wr_data;
        if (lk_req && !maint && hit_any) begin
            if (!sel.pv) begin
                d.rc = RES_FAULT;
            end else if ((lk_store && !sel.prot[PROT_WR]) ||
                         (!lk_store && !sel.prot[PROT_RD]) ||
                         (lk_user && !sel.prot[PROT_USR])) begin
                d.rc = RES_VIOL;
            end else begin
                d.rc                 = RES_HIT;
                d.rpa                = {sel.pfn, lk_vaddr[OFF_W-1:0]};
                d.rd                 = sel.dirty | lk_store;
                d.ent[hit_idx].dirty = sel.dirty | lk_store;
                d.mru                = hit_idx;
            end
        end
        if (fill_en) begin
            d.ent[victim].occ   = 1'b1;
            d.ent[victim].vpn   = fill_vpn;
            d.ent[victim].pid   = fill_pid;
            d.ent[victim].pfn   = fill_pfn;
            d.ent[victim].pv    = fill_pv;
            d.ent[victim].prot  = fill_prot;
            d.ent[victim].dirty = 1'b0;
        end else if (inv_en) begin
            for (int i = 0; i < N; i++) begin
                if (inv_all || q.ent[i].pid == inv_pid) d.ent[i].occ = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_valid = q.rv;
    assign res_code  = q.rc;
    assign res_paddr = q.rpa;
    assign res_dirty = q.rd;

    // R2
    res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_valid);
    // R2
    no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !res_valid);
    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (res_code != RES_HIT) ||
                   (res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
    // R7
    store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_store) |=> (res_code != RES_HIT) || res_dirty);
    // R9
    user_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_os) |-> int'(victim) >= OS_N);
    // R8
    victim_not_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && q.ent[victim].occ) |-> victim != q.mru);
    // R11
    maint_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && maint) |=> res_code == RES_MISS);
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int OS_N = 4;

    logic clk = 0, rst_n = 0;
    logic pid_wr_en = 0; logic [7:0] pid_wr_data = 0;
    logic lk_req = 0; logic [31:0] lk_vaddr = 0; logic lk_store = 0, lk_user = 0;
    logic fill_en = 0, fill_os = 0; logic [19:0] fill_vpn = 0, fill_pfn = 0;
    logic [7:0] fill_pid = 0; logic fill_pv = 0; logic [2:0] fill_prot = 0;
    logic inv_en = 0, inv_all = 0; logic [7:0] inv_pid = 0;
    logic res_valid, res_dirty; logic [1:0] res_code; logic [31:0] res_paddr;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_occ[N]; int m_vpn[N], m_pid[N], m_pfn[N], m_prot[N];
    bit m_pv[N], m_dirty[N];
    int m_cur, m_mru;
    bit e_valid, e_dirty; int e_code; longint e_paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_fa u_tlb_fa (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_occ[i]) begin m_occ[i] = 0; m_dirty[i] = 0; end
            m_cur = 0; m_mru = 0; e_valid = 0; e_code = 0; e_paddr = 0; e_dirty = 0;
        end else begin
            int hit; int lo, hi, vic;
            e_valid = lk_req; e_code = 1; e_paddr = 0; e_dirty = 0;
            hit = -1;
            for (int i = 0; i < N; i++)
                if (hit < 0 && m_occ[i] && m_vpn[i] == int'(lk_vaddr[31:12]) && m_pid[i] == m_cur)
                    hit = i;
            if (lk_req && !fill_en && !inv_en && hit >= 0) begin
                bit bad;
                bad = (lk_store && !m_prot[hit][1]) || (!lk_store && !m_prot[hit][0]) ||
                      (lk_user && !m_prot[hit][2]);
                if (!m_pv[hit]) e_code = 2;
                else if (bad) e_code = 3;
                else begin
                    e_code = 0;
                    if (lk_store) m_dirty[hit] = 1;
                    e_dirty = m_dirty[hit];
                    e_paddr = longint'(m_pfn[hit]) * 4096 + lk_vaddr[11:0];
                    m_mru = hit;
                end
            end
            if (fill_en) begin
                lo = fill_os ? 0 : OS_N; hi = fill_os ? OS_N : N; vic = -1;
                for (int i = lo; i < hi; i++) if (vic < 0 && !m_occ[i]) vic = i;
                for (int i = lo; i < hi; i++) if (vic < 0 && i != m_mru) vic = i;
                m_occ[vic] = 1; m_vpn[vic] = fill_vpn; m_pid[vic] = fill_pid;
                m_pfn[vic] = fill_pfn; m_pv[vic] = fill_pv; m_prot[vic] = fill_prot;
                m_dirty[vic] = 0;
            end else if (inv_en) begin
                for (int i = 0; i < N; i++) if (inv_all || m_pid[i] == inv_pid) m_occ[i] = 0;
            end
            if (pid_wr_en) m_cur = pid_wr_data;
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
        checks++;
        if (res_valid !== e_valid ||
            (e_valid && (res_code !== 2'(e_code) ||
                         (e_code == 0 && (res_paddr !== 32'(e_paddr) || res_dirty !== e_dirty))))) begin
            errors++;
            $display("FAIL %s: actual v=%0b c=%0d pa=%h d=%0b expected v=%0b c=%0d pa=%h d=%0b",
                     cur_req, res_valid, res_code, res_paddr, res_dirty,
                     e_valid, e_code, e_paddr[31:0], e_dirty);
        end
        pid_wr_en = 0; lk_req = 0; fill_en = 0; inv_en = 0;
    endtask

    task automatic look(int vpn, int off, bit st, bit usr);
        lk_req = 1; lk_vaddr = {20'(vpn), 12'(off)}; lk_store = st; lk_user = usr; tick();
    endtask
    task automatic fill(bit os, int vpn, int pid, int pfn, bit pv, int prot);
        fill_en = 1; fill_os = os; fill_vpn = 20'(vpn); fill_pid = 8'(pid);
        fill_pfn = 20'(pfn); fill_pv = pv; fill_prot = 3'(prot); tick();
    endtask
    task automatic setpid(int p);
        pid_wr_en = 1; pid_wr_data = 8'(p); tick();
    endtask
    task automatic inval(bit all, int p);
        inv_en = 1; inv_all = all; inv_pid = 8'(p); tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R1"; tick(); tick(); rst_n = 1;
        tick(); look(5, 0, 0, 0); look(0, 0, 0, 1);
        cur_req = "R2"; tick(); look(5, 1, 0, 0); tick();
        cur_req = "R3";
        fill(0, 'h12345, 0, 'hABCDE, 1, 7);
        look('h12345, 'h678, 0, 0); look('h12345, 'hFFF, 0, 1); look('h12346, 0, 0, 0);
        fill(0, 'h12345, 9, 'h11111, 1, 7);
        look('h12345, 'h10, 0, 0);
        cur_req = "R4";
        setpid(9); look('h12345, 'h20, 0, 0);
        pid_wr_en = 1; pid_wr_data = 0; lk_req = 1; lk_vaddr = 32'h12345030; tick();
        look('h12345, 'h40, 0, 0);
        cur_req = "R5";
        fill(0, 'h00700, 0, 'h00777, 0, 0);
        look('h00700, 0, 1, 1); look('h00700, 0, 0, 0); look('h00701, 0, 0, 0);
        cur_req = "R6";
        fill(0, 'h00800, 0, 'h00888, 1, 1);
        look('h00800, 4, 1, 0); look('h00800, 4, 0, 1); look('h00800, 4, 0, 0);
        fill(0, 'h00900, 0, 'h00999, 1, 6);
        look('h00900, 8, 0, 1); look('h00900, 8, 1, 1);
        cur_req = "R7";
        fill(0, 'h00A00, 0, 'h00AAA, 1, 3);
        look('h00A00, 0, 0, 0); look('h00A00, 0, 1, 0); look('h00A00, 0, 0, 0);
        fill(0, 'h00B00, 0, 'h00BBB, 1, 1);
        look('h00B00, 0, 1, 0); look('h00B00, 0, 0, 0);
        cur_req = "R10";
        inval(0, 9); setpid(9); look('h12345, 0, 0, 0); setpid(0);
        look('h12345, 0, 0, 0);
        inval(1, 0); look('h12345, 0, 0, 0); look('h00A00, 0, 0, 0);
        cur_req = "R8";
        for (int k = 0; k < 12; k++) fill(0, 'h100 + k, 0, 'h4000 + k, 1, 7);
        look('h100, 0, 0, 0);
        fill(0, 'h200, 0, 'h5000, 1, 7);
        look('h101, 0, 0, 0); look('h100, 0, 0, 0); look('h200, 0, 0, 0);
        fill(0, 'h201, 0, 'h5001, 1, 7);
        look('h102, 0, 0, 0); look('h201, 0, 0, 0);
        cur_req = "R9";
        for (int k = 0; k < 4; k++) fill(1, 'h900 + k, 0, 'h9000 + k, 1, 3);
        for (int k = 0; k < 14; k++) fill(0, 'h300 + k, 0, 'h6000 + k, 1, 7);
        for (int k = 0; k < 4; k++) look('h900 + k, 0, 0, 0);
        fill(1, 'h910, 0, 'h9100, 1, 3);
        look('h910, 0, 0, 0); look('h900, 0, 0, 0); look('h903, 0, 0, 0);
        cur_req = "R11";
        fill_en = 1; fill_os = 0; fill_vpn = 20'h400; fill_pid = 0; fill_pfn = 20'h7000;
        fill_pv = 1; fill_prot = 7; lk_req = 1; lk_vaddr = 32'h00903000; tick();
        look('h400, 0, 0, 0);
        inv_en = 1; inv_all = 1; lk_req = 1; lk_vaddr = 32'h00400000; tick();
        look('h400, 0, 0, 0);
        fill(0, 'h401, 0, 'h7001, 1, 7);
        fill_en = 1; fill_os = 0; fill_vpn = 20'h402; fill_pid = 0; fill_pfn = 20'h7002;
        fill_pv = 1; fill_prot = 7; inv_en = 1; inv_all = 1; tick();
        look('h401, 0, 0, 0); look('h402, 5, 1, 0);
        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule